// File: doc/BRIEF.md
# Constrained Netlist Chromosome Mutator

This block holds a transistor-netlist chromosome in a local register file and changes it by random point mutations. Each transistor owns four genes (polarity, gate connection, source connection, drain connection), and one further gene per primary output selects the node that drives that output. A pulse on `start` begins a run of `mut_count` legal mutations. An internal LFSR, seeded at start, supplies a random gene index and a random new value for each attempt. The block commits the value only when every electrical connection rule holds. Otherwise it discards the attempt and draws again.

The controller has four states. In IDLE the chromosome can be loaded and read. In SEARCH the block makes one attempt per cycle. FINISH pulses `done`. ABORT pulses `done` together with `err`. The transitions are as follows. IDLE goes to SEARCH on start with a non-zero count, and to FINISH on start with a zero count. SEARCH goes to FINISH when the last requested mutation is accepted. SEARCH goes to ABORT when the attempt budget runs out first. FINISH and ABORT both return to IDLE after one cycle.

Top module: `netlist_mutator`

## Requirements
- R1: Gene layout and node numbering. Gene 4t is the polarity of transistor t, stored as bit 0 only (1 = PMOS, 0 = NMOS). Gene 4t+1 is its gate, gene 4t+2 its source and gene 4t+3 its drain. Gene 4K+o selects output o. The node numbers are: ground 0, supply 1, input j (j from 1 to NI) node 1+j, node NI+2 unused. Transistor t has its gate terminal at NI+3+3t, its source at NI+4+3t and its drain at NI+5+3t. In IDLE, `wr_en` writes `wr_val` to gene `wr_idx`. `rd_val` shows gene `rd_idx` combinationally. An index of G or more reads as 0 and is not written.
- R2: The LFSR is a 16-bit Galois register that shifts right with feedback mask 0xB400. On start it loads `seed`, or 1 when `seed` is 0. It advances once per SEARCH cycle. Each attempt takes its gene index from the LFSR's low GW bits and its new value from the next NW bits. An index of G or more is rejected.
- R3: A gate gene accepts only primary-input nodes 2 to NI+1.
- R4: A source or drain gene accepts only ground, supply, or the source or drain terminal of another transistor. It never accepts a terminal of its own transistor.
- R5: A PMOS source or drain never takes ground, and an NMOS source or drain never takes supply. A polarity change is rejected when the transistor's own source or drain holds the rail forbidden for the new polarity.
- R6: An output gene accepts any existing node from 2 upward except the unused node NI+2.
- R7: An attempt whose value equals the gene's current value is rejected.
- R8: A source or drain change is rejected when it would remove the only remaining supply connection, or the only remaining ground connection.
- R9: `done` is a one-cycle pulse. It comes in the cycle after the m-th accepted attempt, or in the cycle after start when `mut_count` is 0.
- R10: If m acceptances are not reached within 1024 attempts, `done` and `err` pulse together. Accepted changes are kept.
- R11: Writes while a run is active, or in the same cycle as start, are ignored. Start is ignored while a run is active.
- R12: After reset the block is in IDLE, `done` and `err` are 0, and every gene reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a mutation run |
| mut_count | input | MW | Number of legal mutations requested |
| seed | input | LW | LFSR seed loaded at start |
| wr_en | input | 1 | Gene write strobe (IDLE only) |
| wr_idx | input | GW | Gene index to write |
| wr_val | input | NW | Value to write |
| rd_idx | input | GW | Gene index to read |
| rd_val | output | NW | Value of gene `rd_idx` |
| done | output | 1 | Run finished (one cycle) |
| err | output | 1 | Attempt budget exhausted (with `done`) |

## Verification
The bench builds the block with its default parameters: two inputs, four transistors and one output. That gives 17 genes and 17 nodes, so both the gene index and the value are 5 bits wide. At this size, nearly half of all draws land on an index of 17 or more, or on the unused node 4. Every rule, including the last-rail guard, is therefore reached within a few hundred attempts. A request for 255 mutations cannot be met inside the 1024-attempt budget, which drives the run into ABORT.

// File: rtl/mut_pkg.sv
package mut_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_FINISH = 2'd2,
        ST_ABORT  = 2'd3
    } mut_state_e;
endpackage

// File: rtl/mut_lfsr.sv
module mut_lfsr #(
    parameter int          LW   = 16,
    parameter logic [LW-1:0] TAPS = 16'hB400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] seed,
    input  logic          step,
    output logic [LW-1:0] q
);
    logic [LW-1:0] nxt;

    always_comb nxt = (q >> 1) ^ (q[0] ? TAPS : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= LW'(1);
        else if (load)
            q <= (seed == '0) ? LW'(1) : seed;
        else if (step)
            q <= nxt;
    end
endmodule

// File: rtl/gene_store.sv
module gene_store #(
    parameter int NI = 2,
    parameter int K  = 4,
    parameter int NO = 1,
    localparam int NODES = NI + 3 + 3 * K,
    localparam int NW    = $clog2(NODES),
    localparam int G     = 4 * K + NO,
    localparam int GW    = $clog2(G),
    localparam int CW    = $clog2(2 * K + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [GW-1:0]         widx,
    input  logic [NW-1:0]         wval,
    input  logic [GW-1:0]         ridx,
    output logic [NW-1:0]         rval,
    output logic [G-1:0][NW-1:0]  genes,
    output logic [CW-1:0]         cnt_vcc,
    output logic [CW-1:0]         cnt_gnd
);
    logic [NW-1:0] mem [G];

    for (genvar i = 0; i < G; i++) begin : g_gene
        if (i < 4 * K && (i % 4) == 0) begin : g_pol
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (we && widx == GW'(i))
                    mem[i] <= {{(NW-1){1'b0}}, wval[0]};
            end
        end else begin : g_node
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (we && widx == GW'(i))
                    mem[i] <= wval;
            end
        end
        assign genes[i] = mem[i];
    end

    always_comb rval = (int'(ridx) < G) ? mem[ridx] : '0;

    // count source/drain attachments to each rail
    always_comb begin
        int nv, ng;
        nv = 0;
        ng = 0;
        for (int t = 0; t < K; t++) begin
            if (mem[4*t+2] == NW'(1)) nv++;
            if (mem[4*t+3] == NW'(1)) nv++;
            if (mem[4*t+2] == NW'(0)) ng++;
            if (mem[4*t+3] == NW'(0)) ng++;
        end
        cnt_vcc = CW'(nv);
        cnt_gnd = CW'(ng);
    end
endmodule

// File: rtl/rule_check.sv
module rule_check #(
    parameter int NI = 2,
    parameter int K  = 4,
    parameter int NO = 1,
    localparam int NODES = NI + 3 + 3 * K,
    localparam int NW    = $clog2(NODES),
    localparam int G     = 4 * K + NO,
    localparam int GW    = $clog2(G),
    localparam int CW    = $clog2(2 * K + 1)
) (
    input  logic [G-1:0][NW-1:0] genes,
    input  logic [GW-1:0]        gidx,
    input  logic [NW-1:0]        val,
    input  logic [CW-1:0]        cnt_vcc,
    input  logic [CW-1:0]        cnt_gnd,
    output logic                 ok
);
    always_comb begin
        int gi, v, old, t, s, d, own_s, own_d;
        logic pm, sd;
        gi = int'(gidx);
        v  = int'(val);
        ok = 1'b0;
        if (gi < G) begin
            old = int'(genes[gi]);
            if (gi >= 4 * K) begin
                ok = (v != old) && (v >= 2) && (v < NODES) && (v != NI + 2);
            end else begin
                t     = gi / 4;
                pm    = genes[4*t][0];
                s     = int'(genes[4*t+2]);
                d     = int'(genes[4*t+3]);
                own_s = NI + 4 + 3 * t;
                own_d = NI + 5 + 3 * t;
                sd    = (v <= 1);
                for (int u = 0; u < K; u++)
                    if (v == NI + 4 + 3 * u || v == NI + 5 + 3 * u) sd = 1'b1;
                unique case (gi % 4)
                    0: ok = (val[0] != pm) &&
                            (val[0] ? (s != 0 && d != 0) : (s != 1 && d != 1));
                    1: ok = (v != old) && (v >= 2) && (v <= NI + 1);
                    default: ok = (v != old) && sd && (v != own_s) && (v != own_d)
                                  && !(pm && v == 0) && !(!pm && v == 1)
                                  && !(old == 1 && int'(cnt_vcc) == 1)
                                  && !(old == 0 && int'(cnt_gnd) == 1);
                endcase
            end
        end
    end
endmodule

// File: rtl/netlist_mutator.sv
module netlist_mutator #(
    parameter int NI        = 2,
    parameter int K         = 4,
    parameter int NO        = 1,
    parameter int MW        = 8,
    parameter int LW        = 16,
    parameter int MAX_TRIES = 1024,
    localparam int NODES = NI + 3 + 3 * K,
    localparam int NW    = $clog2(NODES),
    localparam int G     = 4 * K + NO,
    localparam int GW    = $clog2(G),
    localparam int CW    = $clog2(2 * K + 1),
    localparam int TW    = $clog2(MAX_TRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] mut_count,
    input  logic [LW-1:0] seed,
    input  logic          wr_en,
    input  logic [GW-1:0] wr_idx,
    input  logic [NW-1:0] wr_val,
    input  logic [GW-1:0] rd_idx,
    output logic [NW-1:0] rd_val,
    output logic          done,
    output logic          err
);
    import mut_pkg::*;

    mut_state_e           st_q, st_d;
    logic [MW-1:0]        rem_q;
    logic [TW-1:0]        tries_q;
    logic [LW-1:0]        rnd;
    logic                 legal, commit, st_we;
    logic [GW-1:0]        draw_idx, st_idx;
    logic [NW-1:0]        draw_val, st_val;
    logic [G-1:0][NW-1:0] genes;
    logic [CW-1:0]        cnt_vcc, cnt_gnd;

    assign draw_idx = rnd[GW-1:0];
    assign draw_val = rnd[GW +: NW];
    assign commit   = (st_q == ST_SEARCH) && legal;
    assign st_we    = commit || (st_q == ST_IDLE && wr_en && !start);
    assign st_idx   = commit ? draw_idx : wr_idx;
    assign st_val   = commit ? draw_val : wr_val;

    mut_lfsr #(.LW(LW)) u_lfsr (
        .clk(clk), .rst_n(rst_n),
        .load(st_q == ST_IDLE && start), .seed(seed),
        .step(st_q == ST_SEARCH), .q(rnd)
    );

    gene_store #(.NI(NI), .K(K), .NO(NO)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .widx(st_idx), .wval(st_val),
        .ridx(rd_idx), .rval(rd_val), .genes(genes),
        .cnt_vcc(cnt_vcc), .cnt_gnd(cnt_gnd)
    );

    rule_check #(.NI(NI), .K(K), .NO(NO)) u_rules (
        .genes(genes), .gidx(draw_idx), .val(draw_val),
        .cnt_vcc(cnt_vcc), .cnt_gnd(cnt_gnd), .ok(legal)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = (mut_count == '0) ? ST_FINISH : ST_SEARCH;
            ST_SEARCH: if (legal && rem_q == MW'(1)) st_d = ST_FINISH;
                       else if (tries_q == TW'(MAX_TRIES - 1)) st_d = ST_ABORT;
            ST_FINISH: st_d = ST_IDLE;
            ST_ABORT:  st_d = ST_IDLE;
        endcase
    end

    // state register and run counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            rem_q   <= '0;
            tries_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) begin
                rem_q   <= mut_count;
                tries_q <= '0;
            end else if (st_q == ST_SEARCH) begin
                tries_q <= tries_q + TW'(1);
                if (legal) rem_q <= rem_q - MW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        done = (st_q == ST_FINISH) || (st_q == ST_ABORT);
        err  = (st_q == ST_ABORT);
    end
endmodule

// File: rtl/mut_checker.sv
module mut_checker #(
    parameter int MW = 8,
    parameter int GW = 5,
    parameter int NW = 5,
    parameter int CW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [MW-1:0]      mut_count,
    input logic               wr_en,
    input logic [GW-1:0]      rd_idx,
    input logic [NW-1:0]      rd_val,
    input logic               done,
    input logic               err,
    input mut_pkg::mut_state_e st_q,
    input logic [CW-1:0]      cnt_vcc,
    input logic [CW-1:0]      cnt_gnd
);
    import mut_pkg::*;

    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start && mut_count == '0) |=> done);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !wr_en) |=> (rd_idx != $past(rd_idx) || rd_val == $past(rd_val)));

    assert_keep_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEARCH && cnt_vcc != '0) |=> cnt_vcc != '0);

    assert_keep_ground_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEARCH && cnt_gnd != '0) |=> cnt_gnd != '0);
endmodule

bind netlist_mutator mut_checker #(.MW(MW), .GW(GW), .NW(NW), .CW(CW)) u_mut_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .mut_count(mut_count),
    .wr_en(wr_en), .rd_idx(rd_idx), .rd_val(rd_val), .done(done), .err(err),
    .st_q(st_q), .cnt_vcc(cnt_vcc), .cnt_gnd(cnt_gnd)
);

// File: tb/test_netlist_mutator.sv
`timescale 1ns/1ps
module test_netlist_mutator;
    localparam int NI = 2, K = 4, NO = 1;
    localparam int NODES = NI + 3 + 3 * K;
    localparam int NW = $clog2(NODES);
    localparam int G = 4 * K + NO;
    localparam int GW = $clog2(G);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] mut_count = '0;
    logic [15:0] seed = '0;
    logic wr_en = 1'b0;
    logic [GW-1:0] wr_idx = '0;
    logic [NW-1:0] wr_val = '0;
    logic [GW-1:0] rd_idx = '0;
    logic [NW-1:0] rd_val;
    logic done, err;

    always #10 clk = ~clk;

    netlist_mutator i_netlist_mutator (
        .clk(clk), .rst_n(rst_n), .start(start), .mut_count(mut_count), .seed(seed),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .rd_idx(rd_idx),
        .rd_val(rd_val), .done(done), .err(err)
    );

    int n_tests = 0, n_fail = 0;

    // behavioural reference model
    int m_st = 0;            // 0 idle, 1 searching, 2 done, 3 aborted
    int m_lfsr = 1, m_rem = 0, m_tries = 0;
    int m_gene [G];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_legal(input int g, input int v);
        int old, t, f, tp, s, d, nv, ng;
        bit sd;
        if (g >= G) return 0;
        old = m_gene[g];
        if (g >= 4 * K) return v != old && v >= 2 && v < NODES && v != NI + 2;
        t = g / 4; f = g % 4;
        tp = m_gene[4*t]; s = m_gene[4*t+2]; d = m_gene[4*t+3];
        if (f == 0) begin
            if ((v % 2) == tp) return 0;
            if (v % 2 == 1) return s != 0 && d != 0;
            return s != 1 && d != 1;
        end
        if (f == 1) return v != old && v >= 2 && v <= NI + 1;
        nv = 0; ng = 0;
        for (int u = 0; u < K; u++) begin
            for (int e = 2; e < 4; e++) begin
                if (m_gene[4*u+e] == 1) nv++;
                if (m_gene[4*u+e] == 0) ng++;
            end
        end
        sd = (v <= 1) || (v >= NI + 3 && v < NODES && ((v - NI - 3) % 3) != 0);
        if (!sd || v == old) return 0;
        if (v == NI + 4 + 3 * t || v == NI + 5 + 3 * t) return 0;
        if (tp == 1 && v == 0) return 0;
        if (tp == 0 && v == 1) return 0;
        if (old == 1 && nv == 1) return 0;
        if (old == 0 && ng == 1) return 0;
        return 1;
    endfunction

    task automatic m_step();
        int g, v;
        case (m_st)
            0: begin
                if (start) begin
                    m_lfsr = (seed == 0) ? 1 : int'(seed);
                    m_rem = int'(mut_count); m_tries = 0;
                    m_st = (mut_count == 0) ? 2 : 1;
                end else if (wr_en && int'(wr_idx) < G) begin
                    m_gene[wr_idx] = (wr_idx < 4 * K && wr_idx % 4 == 0) ? int'(wr_val) % 2 : int'(wr_val);
                end
            end
            1: begin
                g = m_lfsr % (1 << GW);
                v = (m_lfsr >> GW) % (1 << NW);
                if (m_legal(g, v)) begin
                    m_gene[g] = (g < 4 * K && g % 4 == 0) ? v % 2 : v;
                    m_rem--;
                end
                if (m_legal_done()) m_st = 2;
                else if (m_tries == 1023) m_st = 3;
                m_tries++;
                m_lfsr = (m_lfsr >> 1) ^ ((m_lfsr % 2 == 1) ? 'hB400 : 0);
            end
            default: m_st = 0;
        endcase
    endtask

    function automatic bit m_legal_done();
        return m_rem == 0;
    endfunction

    task automatic tick();
        m_step();
        @(posedge clk);
        @(negedge clk);
        check(done === (m_st == 2 || m_st == 3), "R9 done", int'(done), int'(m_st >= 2));
        check(err === (m_st == 3), "R10 err", int'(err), int'(m_st == 3));
    endtask

    task automatic write_gene(input int g, input int v);
        wr_en = 1'b1; wr_idx = GW'(g); wr_val = NW'(v);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        for (int g = 0; g < G; g++) begin
            rd_idx = GW'(g);
            #1;
            check(int'(rd_val) == m_gene[g], tag, int'(rd_val), m_gene[g]);
        end
    endtask

    task automatic run(input int sd, input int m, input bit poke);
        int guard;
        seed = 16'(sd); mut_count = 8'(m); start = 1'b1;
        tick();
        start = 1'b0;
        guard = 0;
        while (m_st != 0 && guard < 3000) begin
            // R11: write and restart attempts while busy must be ignored
            wr_en = poke; wr_idx = GW'(16); wr_val = NW'(3); start = poke;
            tick();
            guard++;
        end
        wr_en = 1'b0; start = 1'b0;
        compare_all("R2 R3 R4 R5 R6 R7 R8 R11 genes");
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int g = 0; g < G; g++) m_gene[g] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        check(done === 1'b0 && err === 1'b0, "R12 flags", int'(done), 0);
        compare_all("R12 genes zero");
        // R1 load a legal chromosome: t0 P(g2,s1,d9) t1 P(g3,s1,d6) t2 N(g2,s0,d15) t3 N(g3,s0,d12), out=6
        write_gene(0, 7);  write_gene(1, 2); write_gene(2, 1); write_gene(3, 9);
        write_gene(4, 1);  write_gene(5, 3); write_gene(6, 1); write_gene(7, 6);
        write_gene(8, 0);  write_gene(9, 2); write_gene(10, 0); write_gene(11, 15);
        write_gene(12, 0); write_gene(13, 3); write_gene(14, 0); write_gene(15, 12);
        write_gene(16, 6);
        write_gene(20, 9);   // R1 out-of-range write ignored
        compare_all("R1 load readback");
        rd_idx = GW'(20); #1;
        check(rd_val == '0, "R1 out-of-range read", int'(rd_val), 0);
        // R9 zero-count run
        run(16'h0001, 0, 1'b0);
        run(16'hACE1, 1, 1'b0);
        run(16'h1234, 3, 1'b0);
        run(16'h0000, 5, 1'b0);   // R2 zero seed becomes 1
        run(16'h5A5A, 8, 1'b1);   // R11 pokes during the run
        // R11 write in the same cycle as start is dropped
        wr_en = 1'b1; wr_idx = GW'(16); wr_val = NW'(13);
        run(16'h7777, 2, 1'b0);
        // R10 unreachable request aborts
        run(16'hBEEF, 255, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule